// File: doc/BRIEF.md
# Inbound Address Translation Windows

This block sits on the receive side of a bridge between an external PCI-style bus and an AHB-style system bus. Every inbound access address is checked against a small bank of programmable windows. A window is a naturally aligned, power-of-two region of the PCI address space. Its size is not stored as a length. Each window holds a count N of upper address bits to substitute. When the top N bits of the inbound address equal the top N bits of the window's PCI base, the window claims the access. Those N bits are then replaced by the window's system-side base, and the lower bits pass through unchanged as the offset.

Each window has two registers, both written through a simple write port and read back combinationally. The base register holds the PCI-side base. The control register holds the system-side base, the bit count and an access flag. A global enable register carries one bit per window. When several windows claim the same address, the lowest-numbered one wins. An address that no window claims is flagged as a miss. The lookup is combinational from the inbound address and is followed by a single output register stage.

Top module: `inbound_window_xlate`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and out_valid and out_miss are low. Zero registers mean every window is disabled and every bit count is zero.
- R2: Register select uses reg_addr[3] = 1 for the global enable register, whose bit w enables window w. When reg_addr[3] = 0, reg_addr[2:1] is the window and reg_addr[0] chooses the register: 0 for the base, 1 for the control register. The base register keeps bits [31:10] and reads 0 below them. The control register keeps the system base in [31:10], the bit count N in [9:4] and the access flag in bit 0, and bits [3:1] read 0.
- R3: A window claims an access when its global enable bit and access flag are both set, N is in the range 1..22, and the top N bits of in_addr equal the top N bits of its base. For example, N = 22 gives a 1 KB window.
- R4: A window whose bit count is 0, or greater than 22, never claims an access.
- R5: For a claimed access, out_addr takes its top N bits from the system base and its remaining bits from in_addr. System base bits below the top N are ignored.
- R6: When several windows claim one address, out_win reports the lowest-numbered of them, and out_addr uses that window's translation.
- R7: When in_valid is high and no window claims the address, out_miss is 1, out_valid is 0, and out_addr and out_win are 0.
- R8: The results for an access presented with in_valid appear one clock later. A cycle with in_valid low gives out_valid = 0 and out_miss = 0 on the next cycle.
- R9: A register write first affects accesses presented on the cycle after the write. An access in the same cycle as the write still sees the old contents.
- R10: Clearing a window's global enable bit, or its access flag, stops that window from claiming accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| in_valid | input | 1 | Inbound access present |
| in_addr | input | 32 | Inbound PCI-side address |
| out_valid | output | 1 | Registered: access claimed and translated |
| out_miss | output | 1 | Registered: access claimed by no window |
| out_win | output | 2 | Index of the claiming window |
| out_addr | output | 32 | Translated system-side address |

## Verification
The lookup is exercised in several ways. Single-window hits check that the bits are substituted at the right width. Addresses one byte inside and one byte outside a 1 KB window check the match boundary. Overlapping windows separate priority from plain matching. Base and count writes made in the same cycle as an access show whether the update takes effect one cycle later. A long stretch of random addresses drawn near the programmed bases is then mixed with random rewrites of counts, access flags and enables, including illegal counts. Throughout, a behavioural model in the bench is compared with the outputs on every clock.

// File: rtl/ibw_pkg.sv
// Package: shared field positions and register-select encoding for the
// inbound address translation windows.
// Assumes the control-register fields all fit below the minimum window size.
package ibw_pkg;

    // Field layout of a window control register
    localparam int IBW_CNT_LSB = 4;  // bit count field starts here
    localparam int IBW_CNT_W   = 6;  // bit count field width
    localparam int IBW_ACC_BIT = 0;  // access flag position

    // Register choice inside one window (reg_addr[0])
    typedef enum logic {
        SEL_BASE = 1'b0,
        SEL_CTRL = 1'b1
    } ibw_sel_e;

endpackage

// File: rtl/ibw_regs.sv
// Module: ibw_regs
// Holds the per-window base and control registers and the global enable
// register, and provides a write port with combinational read-back.
// Assumes: NUM_WIN >= 2, MIN_LOG2 > control field top bit, synchronous
// active-low reset. The register select is {global, window[WIN_IW-1:0], sel}.
module ibw_regs
    import ibw_pkg::*;
#(
    parameter int AW       = 32,
    parameter int NUM_WIN  = 4,
    parameter int MIN_LOG2 = 10,
    localparam int WIN_IW  = $clog2(NUM_WIN),
    localparam int RA_W    = WIN_IW + 2,
    localparam int HI_W    = AW - MIN_LOG2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_wr,
    input  logic [RA_W-1:0]                    reg_addr,
    input  logic [AW-1:0]                      reg_wdata,
    output logic [AW-1:0]                      reg_rdata,
    output logic [NUM_WIN-1:0][HI_W-1:0]       base_hi,
    output logic [NUM_WIN-1:0][HI_W-1:0]       sys_hi,
    output logic [NUM_WIN-1:0][IBW_CNT_W-1:0]  cnt,
    output logic [NUM_WIN-1:0]                 acc,
    output logic [NUM_WIN-1:0]                 gen
);

    localparam logic [WIN_IW:0] NW_C = (WIN_IW + 1)'(NUM_WIN);

    logic              is_glob;
    logic [WIN_IW-1:0] win_sel;
    ibw_sel_e          reg_sel;
    logic              win_ok;
    logic              unused_wbits;

    // Split the register select into its fields
    always_comb begin
        is_glob = reg_addr[RA_W-1];
        win_sel = reg_addr[WIN_IW:1];
        reg_sel = ibw_sel_e'(reg_addr[0]);
        win_ok  = ({1'b0, win_sel} < NW_C);
    end

    // Reserved control bits between the access flag and the count field
    assign unused_wbits = ^reg_wdata[IBW_CNT_LSB-1:IBW_ACC_BIT+1];

    // Register storage: reset clears everything, a write updates one register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_hi <= '0;
            sys_hi  <= '0;
            cnt     <= '0;
            acc     <= '0;
            gen     <= '0;
        end else if (reg_wr) begin
            if (is_glob) begin
                gen <= reg_wdata[NUM_WIN-1:0];
            end else if (win_ok) begin
                if (reg_sel == SEL_BASE) begin
                    base_hi[win_sel] <= reg_wdata[AW-1:MIN_LOG2];
                end else begin
                    sys_hi[win_sel] <= reg_wdata[AW-1:MIN_LOG2];
                    cnt[win_sel]    <= reg_wdata[IBW_CNT_LSB +: IBW_CNT_W];
                    acc[win_sel]    <= reg_wdata[IBW_ACC_BIT];
                end
            end
        end
    end

    // Read mux: assemble the addressed register, zeros in unused bits
    always_comb begin
        reg_rdata = '0;
        if (is_glob) begin
            reg_rdata[NUM_WIN-1:0] = gen;
        end else if (win_ok) begin
            if (reg_sel == SEL_BASE) begin
                reg_rdata[AW-1:MIN_LOG2] = base_hi[win_sel];
            end else begin
                reg_rdata[AW-1:MIN_LOG2]              = sys_hi[win_sel];
                reg_rdata[IBW_CNT_LSB +: IBW_CNT_W]   = cnt[win_sel];
                reg_rdata[IBW_ACC_BIT]                = acc[win_sel];
            end
        end
    end

    // A control write lands in the addressed window's count next cycle
    AST_CTRL_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !is_glob && win_ok && reg_sel == SEL_CTRL)
        |=> cnt[$past(win_sel)] == $past(reg_wdata[IBW_CNT_LSB +: IBW_CNT_W])); // R2

    // A global enable write is copied into the enable bits
    AST_GEN_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && is_glob) |=> gen == $past(reg_wdata[NUM_WIN-1:0])); // R2

endmodule

// File: rtl/ibw_window.sv
// Module: ibw_window
// Match and translate logic for one window. Builds the upper-bit mask from
// the bit count, compares the inbound address with the PCI base under the
// mask, and forms the translated address from the system base and offset.
// Assumes: bases are stored above MIN_LOG2 and the low bits are zero.
module ibw_window
    import ibw_pkg::*;
#(
    parameter int AW       = 32,
    parameter int MIN_LOG2 = 10,
    localparam int HI_W    = AW - MIN_LOG2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    input  logic [HI_W-1:0]      base_hi,
    input  logic [HI_W-1:0]      sys_hi,
    input  logic [IBW_CNT_W-1:0] cnt,
    input  logic                 acc,
    input  logic                 gen,
    output logic                 hit,
    output logic [AW-1:0]        xaddr
);

    localparam logic [IBW_CNT_W-1:0] MAX_C = IBW_CNT_W'(HI_W);

    logic [AW-1:0] hi_mask;
    logic [AW-1:0] full_base;
    logic [AW-1:0] full_sys;
    logic          cnt_legal;

    // Mask with the top cnt bits set; stored bases widened to full addresses
    always_comb begin
        hi_mask   = ~({AW{1'b1}} >> cnt);
        full_base = {base_hi, {MIN_LOG2{1'b0}}};
        full_sys  = {sys_hi,  {MIN_LOG2{1'b0}}};
        cnt_legal = (cnt != '0) && (cnt <= MAX_C);
    end

    // Claim decision and upper-bit substitution
    always_comb begin
        hit   = gen && acc && cnt_legal && (((addr ^ full_base) & hi_mask) == '0);
        xaddr = (full_sys & hi_mask) | (addr & ~hi_mask);
    end

    // An illegal count never lets the window claim
    AST_BAD_COUNT_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 || cnt > MAX_C) |-> !hit); // R4

    // A disabled window never claims
    AST_DISABLED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen || !acc) |-> !hit); // R10

    // The offset bits below the minimum window always pass through
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> xaddr[MIN_LOG2-1:0] == addr[MIN_LOG2-1:0]); // R5

endmodule

// File: rtl/ibw_pick.sv
// Module: ibw_pick
// Priority selection among the per-window hits (lowest index wins) and
// the single output register stage.
// Assumes: hit and xaddr are combinational from the current inbound address.
module ibw_pick #(
    parameter int AW      = 32,
    parameter int NUM_WIN = 4,
    localparam int WIN_IW = $clog2(NUM_WIN)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [NUM_WIN-1:0]           hit,
    input  logic [NUM_WIN-1:0][AW-1:0]   xaddr,
    output logic                         out_valid,
    output logic                         out_miss,
    output logic [WIN_IW-1:0]            out_win,
    output logic [AW-1:0]                out_addr
);

    logic              found;
    logic [WIN_IW-1:0] sel;
    logic [AW-1:0]     sel_addr;
    logic [NUM_WIN-1:0] below;

    // Scan from the top down so the lowest claiming window is kept last
    always_comb begin
        found    = 1'b0;
        sel      = '0;
        sel_addr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit[i]) begin
                found    = 1'b1;
                sel      = WIN_IW'(i);
                sel_addr = xaddr[i];
            end
        end
    end

    // Windows numbered below the selected one
    assign below = (NUM_WIN'(1) << sel) - NUM_WIN'(1);

    // Output stage: register result, zero index and address unless claimed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_miss  <= 1'b0;
            out_win   <= '0;
            out_addr  <= '0;
        end else begin
            out_valid <= in_valid && found;
            out_miss  <= in_valid && !found;
            out_win   <= (in_valid && found) ? sel : '0;
            out_addr  <= (in_valid && found) ? sel_addr : '0;
        end
    end

    // No claiming window lies below the selected one
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (hit & below) == '0); // R6

    // A miss carries no index and no address
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_miss |-> (out_win == '0 && out_addr == '0)); // R7

    // Hit and miss are never reported together
    AST_VALID_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_miss)); // R7

endmodule

// File: rtl/inbound_window_xlate.sv
// Module: inbound_window_xlate (top)
// Bank of programmable inbound address windows: registers, one match and
// translate unit per window, priority pick and one output register stage.
// Assumes: synchronous active-low reset, register writes take effect on the
// following cycle, and a window's base is aligned to its size.
module inbound_window_xlate
    import ibw_pkg::*;
#(
    parameter int AW       = 32,
    parameter int NUM_WIN  = 4,
    parameter int MIN_LOG2 = 10,
    localparam int WIN_IW  = $clog2(NUM_WIN),
    localparam int RA_W    = WIN_IW + 2,
    localparam int HI_W    = AW - MIN_LOG2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              in_valid,
    input  logic [AW-1:0]     in_addr,
    output logic              out_valid,
    output logic              out_miss,
    output logic [WIN_IW-1:0] out_win,
    output logic [AW-1:0]     out_addr
);

    logic [NUM_WIN-1:0][HI_W-1:0]      base_hi;
    logic [NUM_WIN-1:0][HI_W-1:0]      sys_hi;
    logic [NUM_WIN-1:0][IBW_CNT_W-1:0] cnt;
    logic [NUM_WIN-1:0]                acc;
    logic [NUM_WIN-1:0]                gen;
    logic [NUM_WIN-1:0]                hit;
    logic [NUM_WIN-1:0][AW-1:0]        xaddr;

    ibw_regs #(
        .AW(AW), .NUM_WIN(NUM_WIN), .MIN_LOG2(MIN_LOG2)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .base_hi(base_hi), .sys_hi(sys_hi), .cnt(cnt), .acc(acc), .gen(gen)
    );

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        ibw_window #(
            .AW(AW), .MIN_LOG2(MIN_LOG2)
        ) u_win (
            .clk(clk), .rst_n(rst_n),
            .addr(in_addr),
            .base_hi(base_hi[g]), .sys_hi(sys_hi[g]),
            .cnt(cnt[g]), .acc(acc[g]), .gen(gen[g]),
            .hit(hit[g]), .xaddr(xaddr[g])
        );
    end

    ibw_pick #(
        .AW(AW), .NUM_WIN(NUM_WIN)
    ) u_pick (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .hit(hit), .xaddr(xaddr),
        .out_valid(out_valid), .out_miss(out_miss),
        .out_win(out_win), .out_addr(out_addr)
    );

    // An idle cycle produces no result one clock later
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_miss)); // R8

    // Every presented access produces exactly one result one clock later
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_valid || out_miss)); // R8

endmodule

// File: tb/tb_inbound_window_xlate.sv
module tb_inbound_window_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        out_valid;
    logic        out_miss;
    logic [1:0]  out_win;
    logic [31:0] out_addr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural register model (read-back format)
    logic [31:0] m_base [4];
    logic [31:0] m_ctrl [4];
    logic [3:0]  m_gen;

    always #2 clk = ~clk;   // 250 MHz

    inbound_window_xlate dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .in_valid(in_valid), .in_addr(in_addr),
        .out_valid(out_valid), .out_miss(out_miss),
        .out_win(out_win), .out_addr(out_addr)
    );

    localparam logic [3:0] RA_GEN = 4'h8;
    function automatic logic [3:0] ra_base(input int w); return {1'b0, w[1:0], 1'b0}; endfunction
    function automatic logic [3:0] ra_ctrl(input int w); return {1'b0, w[1:0], 1'b1}; endfunction
    function automatic logic [31:0] mk_ctrl(input logic [31:0] sys, input int n, input bit a);
        return sys | (32'(n) << 4) | 32'(a);
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference lookup: scan windows in ascending order, first claim wins
    task automatic lookup(input logic [31:0] a, output bit h, output int w, output logic [31:0] x);
        h = 0; w = 0; x = '0;
        for (int i = 0; i < 4; i++) begin
            int n = int'(m_ctrl[i][9:4]);
            if (!h && m_gen[i] && m_ctrl[i][0] && n >= 1 && n <= 22) begin
                logic [31:0] mk = 32'hFFFF_FFFF << (32 - n);
                if (((a ^ m_base[i]) & mk) == 0) begin
                    h = 1; w = i; x = (m_ctrl[i] & mk) | (a & ~mk);
                end
            end
        end
    endtask

    task automatic model_write(input logic [3:0] ra, input logic [31:0] wd);
        if (ra[3]) m_gen = wd[3:0];
        else if (!ra[0]) m_base[ra[2:1]] = wd & 32'hFFFF_FC00;
        else m_ctrl[ra[2:1]] = wd & 32'hFFFF_FFF1;
    endtask

    // One clock: drive, predict from pre-write model, compare after the edge
    task automatic step(input bit wr, input logic [3:0] ra, input logic [31:0] wd,
                        input bit v, input logic [31:0] a, input string req);
        bit h; int w; logic [31:0] x;
        logic [63:0] act, exp;
        reg_wr = wr; reg_addr = ra; reg_wdata = wd; in_valid = v; in_addr = a;
        lookup(a, h, w, x);
        @(posedge clk); #1;
        act = {out_valid, out_miss, 28'(out_win), out_addr};
        exp = {v && h, v && !h, 28'((v && h) ? w : 0), (v && h) ? x : 32'h0};
        check(act == exp, req, act, exp);
        if (wr) model_write(ra, wd);
        @(negedge clk);
        reg_wr = 0; in_valid = 0;
    endtask

    task automatic wr(input logic [3:0] ra, input logic [31:0] wd, input string req);
        step(1, ra, wd, 0, 32'h0, req);
    endtask

    task automatic acc(input logic [31:0] a, input string req);
        step(0, 4'h0, 32'h0, 1, a, req);
    endtask

    task automatic rd(input logic [3:0] ra, input logic [31:0] exp, input string req);
        reg_addr = ra; reg_wr = 0;
        #1;
        check(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
    endtask

    initial begin
        #(4 * 200000);
        check(0, "WATCHDOG", 64'(0), 64'(1));
        if (!done) begin
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_base[i] = '0; m_ctrl[i] = '0; end
        m_gen = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        check(!out_valid && !out_miss, "R1", 64'({out_valid, out_miss}), 64'(0));
        for (int i = 0; i < 4; i++) begin
            rd(ra_base(i), 32'h0, "R1");
            rd(ra_ctrl(i), 32'h0, "R1");
        end
        rd(RA_GEN, 32'h0, "R1");
        @(negedge clk);
        acc(32'h4123_4560, "R1");

        // R2: field masking on read-back
        wr(ra_ctrl(3), 32'hFFFF_FFFF, "R2");
        wr(ra_base(3), 32'hFFFF_FFFF, "R2");
        rd(ra_ctrl(3), 32'hFFFF_FFF1, "R2");
        rd(ra_base(3), 32'hFFFF_FC00, "R2");
        wr(RA_GEN, 32'hFFFF_FFF5, "R2");
        rd(RA_GEN, 32'h0000_0005, "R2");
        @(negedge clk);
        wr(ra_ctrl(3), 32'h0, "R2");
        wr(ra_base(3), 32'h0, "R2");
        wr(RA_GEN, 32'h0, "R2");

        // R10: programmed but globally disabled window does not claim
        wr(ra_base(0), 32'h4000_0000, "R2");
        wr(ra_ctrl(0), mk_ctrl(32'h8000_0000, 4, 1), "R2");
        acc(32'h4123_4560, "R10");
        // R9: access in the same cycle as the enabling write still misses
        step(1, RA_GEN, 32'h1, 1, 32'h4123_4560, "R9");
        // R5: next cycle it hits with the top 4 bits replaced
        acc(32'h4123_4560, "R5");
        acc(32'h4FFF_FFFF, "R5");
        acc(32'h5000_0000, "R7");

        // R6: overlapping window 1 (N=8); window 0 wins
        wr(ra_base(1), 32'h4000_0000, "R2");
        wr(ra_ctrl(1), mk_ctrl(32'h12FF_FC00, 8, 1), "R2");
        wr(RA_GEN, 32'h3, "R2");
        acc(32'h40AB_CDEF, "R6");
        // R5: move window 1; low system base bits ignored
        step(1, ra_base(1), 32'h5000_0000, 1, 32'h5012_3456, "R9");
        acc(32'h5012_3456, "R5");
        acc(32'h5112_3456, "R7");

        // R3: 1 KB window boundaries (N=22)
        wr(ra_base(2), 32'hABCD_E400, "R2");
        wr(ra_ctrl(2), mk_ctrl(32'h0000_0C00, 22, 1), "R2");
        wr(RA_GEN, 32'h7, "R2");
        acc(32'hABCD_E7FF, "R3");
        acc(32'hABCD_E400, "R3");
        acc(32'hABCD_E800, "R3");
        acc(32'hABCD_E3FF, "R3");

        // R4: illegal counts 23 and 0
        wr(ra_base(3), 32'hC000_0000, "R2");
        wr(ra_ctrl(3), mk_ctrl(32'h0000_0000, 23, 1), "R2");
        wr(RA_GEN, 32'hF, "R2");
        acc(32'hC000_0000, "R4");
        wr(ra_ctrl(3), mk_ctrl(32'h0000_0000, 0, 1), "R4");
        acc(32'hC000_0000, "R4");
        wr(ra_ctrl(3), mk_ctrl(32'h2000_0000, 1, 1), "R3");
        acc(32'hC000_1234, "R3");

        // R10: clearing the access flag of window 0 hands over to window 1? no: miss
        wr(ra_ctrl(0), mk_ctrl(32'h8000_0000, 4, 0), "R10");
        acc(32'h4123_4560, "R10");
        wr(RA_GEN, 32'hD, "R10");
        acc(32'h5012_3456, "R10");

        // R8: idle cycles
        step(0, 4'h0, 32'h0, 0, 32'hABCD_E500, "R8");
        step(0, 4'h0, 32'h0, 0, 32'h0, "R8");

        // Random mix compared with the model every clock
        for (int k = 0; k < 600; k++) begin
            int r = int'($urandom_range(0, 9));
            int w = int'($urandom_range(0, 3));
            logic [31:0] a = m_base[w] ^ (32'($urandom) >> $urandom_range(0, 31));
            if (r == 0) begin
                int n = int'($urandom_range(0, 24));
                step(1, ra_ctrl(w), mk_ctrl(32'($urandom), n, 1'($urandom_range(0, 3) != 0)),
                     1, a, "R3");
            end else if (r == 1) begin
                step(1, RA_GEN, 32'($urandom), 1, a, "R10");
            end else if (r == 2) begin
                step(1, ra_base(w), 32'($urandom), 1, a, "R9");
            end else if (r == 3) begin
                step(0, 4'h0, 32'h0, 0, a, "R8");
            end else begin
                step(0, 4'h0, 32'h0, 1, a, "R6");
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule